// File: doc/BRIEF.md
# External Memory Bus Strobe Generator

This block generates the pin-level timing strobes that an 8-bit microcontroller core needs to talk to external code and data memory. It runs directly from the oscillator clock. Each machine cycle lasts twelve oscillator periods, made of six states of two periods each. For every machine cycle the core states what the cycle does. The choices are an internal or external instruction fetch, a 16-bit or 8-bit addressed external data read or write, or a code-table read. From that declaration the block drives these outputs:

- the address-latch pulse;
- the active-low code-read strobe;
- the active-low data read and write strobes;
- a mode code for the shared low address/data bus;
- a source code for the high address byte.

The address-latch pulse runs freely, twice per machine cycle. It is withheld in only two cases. The first is the leading slot of the cycle that follows a data-memory access. The second is when a suppress control is set and the cycle performs no external activity. A data access spans two machine cycles. The declared cycle puts out the data address in its second half. The cycle after it carries the read or write strobe in its first half, and the kind the core declares for that cycle is ignored.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `rstN` is low, `ale` is 0; `psenN`, `rdN` and `wrN` are 1; `lowBus` and `hiSrc` are 0; and `kindTake` is 1.
- R2: A machine cycle is 12 clocks, numbered slot 0 to 11. `kindTake` is high in slot 11 only. `accKind` is sampled on the edge that ends slot 11 and governs the next 12 slots. The codes are: 0 internal fetch, 1 external fetch, 2 read/16-bit, 3 write/16-bit, 4 read/8-bit, 5 write/8-bit, 6 code-table read.
- R3: With `aleOff`=0, `ale` is high for one clock in slot 1 and in slot 7 of every cycle, except where R6 removes a pulse.
- R4: An external code half drives `psenN` low in slots 2–5 (first half) or 8–11 (second half). In the same half, `lowBus` is 1 (address) in the first two slots and 2 (input) during the strobe, and `hiSrc` is 1 (program counter). Both halves are external code halves for code 1 and code 6. Both halves are also external code halves for any code while `extOnly`=1.
- R5: In a data-access cycle (codes 2–5), slots 8–11 keep `psenN` high. In slots 6–7, `lowBus` is 1. In slots 8–11, `lowBus` is 3 (output) for a write and 2 for a read. Over slots 6–11, `hiSrc` is 2 (data pointer) for 16-bit codes and 0 (port latch) for 8-bit codes.
- R6: In the cycle after a data access, `rdN` (read) or `wrN` (write) is low in slots 0–5. In that cycle, `ale` stays low in slot 1, `psenN` stays high in slots 0–5, `lowBus` is 2 (read) or 3 (write) in slots 0–5, and `hiSrc` follows the width rule of R5 in slots 0–5. The `accKind` presented for that cycle is ignored. Its second half is an external code half only if `extOnly`=1.
- R7: With `aleOff`=1 and `extOnly`=0, an internal-fetch cycle (code 0) has no `ale` pulse. All other outputs of that cycle are unchanged.
- R8: `aleOff` has no effect during data-access cycles, the cycle after them, or code-table reads.
- R9: `aleOff` has no effect while executing externally, that is with `extOnly`=1 or in a code-1 cycle.
- R10: An internal-fetch cycle with `extOnly`=0 keeps `psenN`, `rdN` and `wrN` high, with `lowBus` and `hiSrc` at 0 in every slot.
- R11: Code 7 behaves exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accKind | input | 3 | Kind of the next machine cycle, sampled at the end of slot 11 |
| extOnly | input | 1 | Strap: all code fetched from external memory |
| aleOff | input | 1 | Suppress the address-latch pulse when the cycle is idle on the bus |
| ale | output | 1 | Address-latch pulse |
| psenN | output | 1 | Active-low code-read strobe |
| rdN | output | 1 | Active-low data read strobe |
| wrN | output | 1 | Active-low data write strobe |
| lowBus | output | 2 | Low bus mode: 0 port latch, 1 low address, 2 input, 3 data output |
| hiSrc | output | 2 | High byte source: 0 port latch, 1 program counter, 2 data pointer |
| kindTake | output | 1 | High in the slot whose closing edge samples `accKind` |

## Verification
The bench targets the cycle that follows a data access. In that cycle it presents an external-fetch code that must be ignored. A design that obeyed that code would pulse `psenN` during the read strobe, and one that failed to skip the first latch pulse would put a stray `ale` in slot 1. Back-to-back accesses of both widths check that `hiSrc` switches between the data pointer and the port latch, and that the write direction of `lowBus` is carried into the second cycle. A design that latched the width or the direction from the wrong cycle would show the wrong source or drive the bus the wrong way. The suppress control is exercised against internal fetch, external execution, data access and code-table reads. A gate wired too broadly or too narrowly would either kill a pulse the external latch needs or leave one running.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // Machine-cycle kind declared by the core
  typedef enum logic [2:0] {
    K_FETCH_INT = 3'd0,
    K_FETCH_EXT = 3'd1,
    K_RD16      = 3'd2,
    K_WR16      = 3'd3,
    K_RD8       = 3'd4,
    K_WR8       = 3'd5,
    K_MOVC      = 3'd6,
    K_SPARE     = 3'd7
  } accKind_e;

  typedef enum logic [1:0] {
    LB_PORT = 2'd0,
    LB_ADDR = 2'd1,
    LB_IN   = 2'd2,
    LB_OUT  = 2'd3
  } lowBus_e;

  typedef enum logic [1:0] {
    HS_PORT = 2'd0,
    HS_PCH  = 2'd1,
    HS_DPH  = 2'd2
  } hiSrc_e;

  // Strobes for one oscillator slot, active high inside the block
  typedef struct packed {
    logic    ale;
    logic    psen;
    logic    rd;
    logic    wr;
    lowBus_e lowBus;
    hiSrc_e  hiSrc;
    logic    take;
  } strobe_t;

  function automatic logic isMovx(accKind_e k);
    return (k == K_RD16) || (k == K_WR16) || (k == K_RD8) || (k == K_WR8);
  endfunction

  function automatic logic isWide(accKind_e k);
    return (k == K_RD16) || (k == K_WR16);
  endfunction

  function automatic logic isWrite(accKind_e k);
    return (k == K_WR16) || (k == K_WR8);
  endfunction

endpackage

// File: rtl/xbus_ctrl.sv
// Slot sequencer and per-half strobe decode. Produces the strobes for the
// slot that starts on the next edge, so the pin stage can register them.
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int OSC_PER_STATE = 2,   // oscillator periods per state (even)
  parameter int STATES        = 6    // states per machine cycle (even)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] accKind,
  input  logic       extOnly,
  input  logic       aleOff,
  output strobe_t    nxtStb
);

  localparam int CYC  = STATES * OSC_PER_STATE;
  localparam int HALF = CYC / 2;
  localparam int TW   = $clog2(CYC);
  localparam logic [TW-1:0] LAST     = TW'(CYC - 1);
  localparam logic [TW-1:0] HALF_T   = TW'(HALF);
  localparam logic [TW-1:0] ALE_LO   = TW'(OSC_PER_STATE / 2);
  localparam logic [TW-1:0] STATE_T  = TW'(OSC_PER_STATE);

  logic [TW-1:0] tick, nTick, pos;
  accKind_e      curKind, nKind;
  logic          dataPh, dataWide, dataWr;
  logic          nDataPh, nWide, nWr;
  logic          wrapNow, inHalfB, movxNow, extExec, codeKind, aleGate;
  logic          aleWin, psenWin, addrWin;
  logic [1:0]    fetchH, aleOnH, roleH, roleWrH, roleWideH;

  // Sequencer next state
  always_comb begin
    wrapNow = (tick == LAST);
    nTick   = wrapNow ? '0 : tick + TW'(1);
    nKind   = wrapNow ? accKind_e'(accKind) : curKind;
    nDataPh = wrapNow ? (!dataPh && isMovx(curKind)) : dataPh;
    nWide   = wrapNow ? isWide(curKind) : dataWide;
    nWr     = wrapNow ? isWrite(curKind) : dataWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick     <= LAST;
      curKind  <= K_FETCH_INT;
      dataPh   <= 1'b0;
      dataWide <= 1'b0;
      dataWr   <= 1'b0;
    end else begin
      tick     <= nTick;
      curKind  <= nKind;
      dataPh   <= nDataPh;
      dataWide <= nWide;
      dataWr   <= nWr;
    end
  end

  // Cycle-level qualifiers for the upcoming slot
  always_comb begin
    inHalfB  = (nTick >= HALF_T);
    pos      = inHalfB ? (nTick - HALF_T) : nTick;
    aleWin   = (pos >= ALE_LO) && (pos < STATE_T);
    psenWin  = (pos >= STATE_T);
    addrWin  = (pos < STATE_T);
    movxNow  = !nDataPh && isMovx(nKind);
    extExec  = extOnly || (!nDataPh && (nKind == K_FETCH_EXT));
    codeKind = (nKind == K_FETCH_EXT) || (nKind == K_MOVC) || extOnly;
    aleGate  = !aleOff || extExec || nDataPh || movxNow || (nKind == K_MOVC);

    fetchH[0]    = !nDataPh && codeKind;
    fetchH[1]    = nDataPh ? extOnly : (!movxNow && codeKind);
    aleOnH       = {1'b1, !nDataPh};
    roleH        = {movxNow, nDataPh};
    roleWrH      = {isWrite(nKind), nWr};
    roleWideH    = {isWide(nKind), nWide};
  end

  // One decoder per half cycle; half 0 carries the data strobe,
  // half 1 carries the data address
  for (genvar h = 0; h < 2; h++) begin : g_half
    strobe_t stb;
    always_comb begin
      stb      = '0;
      stb.ale  = aleWin && aleOnH[h] && aleGate;
      stb.psen = psenWin && fetchH[h] && !roleH[h];
      if (h == 0) begin
        stb.rd = roleH[h] && !roleWrH[h];
        stb.wr = roleH[h] && roleWrH[h];
      end
      if (roleH[h]) begin
        if ((h == 1) && addrWin) stb.lowBus = LB_ADDR;
        else                     stb.lowBus = roleWrH[h] ? LB_OUT : LB_IN;
        stb.hiSrc = roleWideH[h] ? HS_DPH : HS_PORT;
      end else if (fetchH[h]) begin
        stb.lowBus = addrWin ? LB_ADDR : LB_IN;
        stb.hiSrc  = HS_PCH;
      end
    end
  end

  always_comb begin
    nxtStb      = inHalfB ? g_half[1].stb : g_half[0].stb;
    nxtStb.take = (nTick == LAST);
  end

  // R2
  tick_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick <= LAST);

endmodule

// File: rtl/xbus_dp.sv
// Registered pin stage: glitch-free strobes with their pin polarity.
module xbus_dp
  import xbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    nxtStb,
  output logic       ale,
  output logic       psenN,
  output logic       rdN,
  output logic       wrN,
  output logic [1:0] lowBus,
  output logic [1:0] hiSrc,
  output logic       kindTake
);

  localparam strobe_t IDLE_STB = '{ale: 1'b0, psen: 1'b0, rd: 1'b0, wr: 1'b0,
                                   lowBus: LB_PORT, hiSrc: HS_PORT, take: 1'b1};

  strobe_t q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= IDLE_STB;
    else       q <= nxtStb;
  end

  assign ale      = q.ale;
  assign psenN    = !q.psen;
  assign rdN      = !q.rd;
  assign wrN      = !q.wr;
  assign lowBus   = q.lowBus;
  assign hiSrc    = q.hiSrc;
  assign kindTake = q.take;

  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R4
  ale_psen_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> psenN);

  // R6
  rd_bus_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (lowBus == 2'd2));

  // R6
  wr_bus_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (lowBus == 2'd3));

  // R6
  rd_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(kindTake));

  // R2
  take_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    kindTake |=> !kindTake);

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
#(
  parameter int OSC_PER_STATE = 2,
  parameter int STATES        = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] accKind,
  input  logic       extOnly,
  input  logic       aleOff,
  output logic       ale,
  output logic       psenN,
  output logic       rdN,
  output logic       wrN,
  output logic [1:0] lowBus,
  output logic [1:0] hiSrc,
  output logic       kindTake
);

  strobe_t nxtStb;

  xbus_ctrl #(
    .OSC_PER_STATE(OSC_PER_STATE),
    .STATES       (STATES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .accKind(accKind),
    .extOnly(extOnly),
    .aleOff (aleOff),
    .nxtStb (nxtStb)
  );

  xbus_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .nxtStb  (nxtStb),
    .ale     (ale),
    .psenN   (psenN),
    .rdN     (rdN),
    .wrN     (wrN),
    .lowBus  (lowBus),
    .hiSrc   (hiSrc),
    .kindTake(kindTake)
  );

endmodule

// File: tb/sim_xbus_strobe_gen.sv
`timescale 1ns/1ps
module sim_xbus_strobe_gen;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] accKind;
  logic       extOnly, aleOff;
  logic       ale, psenN, rdN, wrN, kindTake;
  logic [1:0] lowBus, hiSrc;

  int  nChk = 0;
  int  nBad = 0;
  bit  done = 1'b0;

  // Bench model state for the two-cycle data access
  logic expDataPh = 1'b0, expWide = 1'b0, expWr = 1'b0;

  always #2.5 clk = ~clk;

  xbus_strobe_gen u0 (
    .clk(clk), .rstN(rstN), .accKind(accKind), .extOnly(extOnly), .aleOff(aleOff),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .lowBus(lowBus), .hiSrc(hiSrc), .kindTake(kindTake)
  );

  // Expected {ale, psenN, rdN, wrN, lowBus, hiSrc, kindTake} per slot
  function automatic logic [8:0] model(input logic [2:0] k, input logic dPh,
                                       input logic dW, input logic dWr,
                                       input logic ext, input logic aOff, input int s);
    logic hb, movx, kW, kWr, code, fetch, a, rd, wr;
    logic [1:0] lb, hs;
    int p;
    hb    = (s >= 6);
    p     = hb ? s - 6 : s;
    movx  = !dPh && (k >= 3'd2) && (k <= 3'd5);
    kW    = (k == 3'd2) || (k == 3'd3);
    kWr   = (k == 3'd3) || (k == 3'd5);
    code  = (k == 3'd1) || (k == 3'd6) || ext;
    fetch = hb ? (dPh ? ext : (!movx && code)) : (!dPh && code);
    a     = (p == 1) && (hb || !dPh) &&
            (!aOff || ext || dPh || movx || (k == 3'd1) || (k == 3'd6));
    rd    = !hb && dPh && !dWr;
    wr    = !hb && dPh && dWr;
    lb    = 2'd0;
    hs    = 2'd0;
    if (!hb && dPh) begin
      lb = dWr ? 2'd3 : 2'd2;
      hs = dW ? 2'd2 : 2'd0;
    end else if (hb && movx) begin
      lb = (p < 2) ? 2'd1 : (kWr ? 2'd3 : 2'd2);
      hs = kW ? 2'd2 : 2'd0;
    end else if (fetch) begin
      lb = (p < 2) ? 2'd1 : 2'd2;
      hs = 2'd1;
    end
    return {a, !(fetch && (p >= 2)), !rd, !wr, lb, hs, (s == 11)};
  endfunction

  function automatic logic [8:0] pins();
    return {ale, psenN, rdN, wrN, lowBus, hiSrc, kindTake};
  endfunction

  task automatic chk(input string tag, input int slot, input logic [8:0] got,
                     input logic [8:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s slot %0d: got %b expected %b (ale psenN rdN wrN lowBus hiSrc take)",
               tag, slot, got, exp);
    end
  endtask

  // Precondition: at a negedge with kindTake high (slot 11 of previous cycle)
  task automatic runCycle(input logic [2:0] k, input string tag);
    logic dPh, dW, dWr;
    dPh = expDataPh; dW = expWide; dWr = expWr;
    accKind = k;
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      chk(tag, s, pins(), model(k, dPh, dW, dWr, extOnly, aleOff, s));
    end
    if (!dPh && (k >= 3'd2) && (k <= 3'd5)) begin
      expDataPh = 1'b1;
      expWide   = (k == 3'd2) || (k == 3'd3);
      expWr     = (k == 3'd3) || (k == 3'd5);
    end else begin
      expDataPh = 1'b0;
    end
  endtask

  task automatic tReset();
    rstN = 1'b0; accKind = 3'd0; extOnly = 1'b0; aleOff = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", i, pins(), 9'b0_1_1_1_00_00_1);
    end
    rstN = 1'b1;
  endtask

  task automatic tCycleLen();
    int takes = 0;
    int misplaced = 0;
    accKind = 3'd0;
    for (int i = 1; i <= 36; i++) begin
      @(negedge clk);
      if (kindTake) begin
        takes++;
        if (i % 12 != 0) misplaced++;
      end
    end
    nChk++;
    if (takes != 3 || misplaced != 0) begin
      nBad++;
      $display("FAIL R2 take pulses: got %0d (%0d misplaced) expected 3 (0)", takes, misplaced);
    end
  endtask

  task automatic tInternal();
    extOnly = 1'b0; aleOff = 1'b0;
    runCycle(3'd0, "R3/R10");
    runCycle(3'd0, "R3/R10");
  endtask

  task automatic tSpare();
    runCycle(3'd7, "R11");
  endtask

  task automatic tExtFetch();
    runCycle(3'd1, "R4");
    runCycle(3'd6, "R4");
    extOnly = 1'b1;
    runCycle(3'd0, "R4");
    extOnly = 1'b0;
  endtask

  task automatic tRead16();
    runCycle(3'd2, "R5");
    runCycle(3'd1, "R6");   // kind ignored in the strobe cycle
    runCycle(3'd0, "R6");
  endtask

  task automatic tWrite8Ext();
    extOnly = 1'b1;
    runCycle(3'd5, "R5");
    runCycle(3'd0, "R6");
    runCycle(3'd0, "R4");
    extOnly = 1'b0;
  endtask

  task automatic tBackToBack();
    runCycle(3'd3, "R5");
    runCycle(3'd4, "R6");   // a second access declared here is ignored
    runCycle(3'd4, "R5");
    runCycle(3'd2, "R6");
    runCycle(3'd0, "R10");
  endtask

  task automatic tAleOff();
    aleOff = 1'b1; extOnly = 1'b0;
    runCycle(3'd0, "R7");
    runCycle(3'd7, "R7");
    runCycle(3'd2, "R8");
    runCycle(3'd0, "R8");
    runCycle(3'd6, "R8");
    runCycle(3'd1, "R9");
    extOnly = 1'b1;
    runCycle(3'd0, "R9");
    extOnly = 1'b0;
    runCycle(3'd0, "R7");
    aleOff = 1'b0;
    runCycle(3'd0, "R3");
  endtask

  initial begin
    tReset();
    tCycleLen();
    tInternal();
    tSpare();
    tExtFetch();
    tRead16();
    tWrite8Ext();
    tBackToBack();
    tAleOff();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule